// File: doc/BRIEF.md
# Dual-CPU Control and Mailbox Registers

This block is a small register file that sits between a main processor and a sub processor. Each side has its own byte/word port. A byte access carries its data in the low eight bits of the write bus, and address bit 0 selects the lane: even is the high byte, odd is the low byte. A 16-bit access writes both lanes of the word at the even address. Reads are combinational and always return the whole 16-bit word at the even address.

The main side holds the controls for the sub processor. It sets the run/reset level and the bus-request level, and it can ring a doorbell that raises a level-2 interrupt pulse on the sub side. The sub side owns an interrupt mask byte that gates this doorbell. Both sides share a flag word in which each side owns one byte. There are also two mailbox banks. The main side writes one bank and the sub side writes the other, and both sides can read every word. A two-bit bank field from the main side is exported for memory mapping elsewhere.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: After reset, run=0 and bus request=1. The reset-pending flag is set. Every other register (flags, mailboxes, mask, bank word) reads zero, and both pulse outputs are low.
- R2: In the control byte (main offset 0x01, bit 0 = run with 0 meaning reset held, bit 1 = bus request), a write with bit 0 = 0 stores bus request = 1 whatever bit 1 carried.
- R3: A control write of exactly 01 while reset-pending is set gives a one-cycle sub_reset_pulse in the cycle after the write, and clears pending. Any control write with bit 0 = 0 sets pending.
- R4: A control write of 11 while pending gives no pulse and keeps pending. A write of 01 when pending is clear gives no pulse.
- R5: A main write with bit 0 = 1 in byte 0x00 (word bit 8 on a 16-bit write) gives a one-cycle sub_irq2 pulse in the following cycle, when mask bit 2 is set.
- R6: The same doorbell write with mask bit 2 clear leaves sub_irq2 low.
- R7: A main read of word 0x00 returns mask bit 2 in bit 15, bus request in bit 1, run in bit 0, and zero elsewhere.
- R8: A main read of word 0x02 returns byte 0x02 in the high byte and byte 0x03 ANDed with 0xC7 in the low byte. prg_bank equals byte 0x03 bits 7:6.
- R9: In the flag word at 0x0E (high byte main-owned, low byte sub-owned), a byte write by either side to 0x0E or 0x0F lands in that side's own byte.
- R10: A main 16-bit write to 0x0E updates only the high byte from data bits 15:8. A sub 16-bit write updates only the low byte from data bits 7:0.
- R11: Words 0x10-0x1F are written only by main and words 0x20-0x2F only by sub. Writes from the other side change nothing, and both sides read all words.
- R12: A byte write to a mailbox changes only the addressed lane (even address = bits 15:8).
- R13: The sub mask byte at 0x33 stores the written value ANDed with 0x7E. A sub read of word 0x32 returns it in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_wr | input | 1 | Main write strobe |
| m_word | input | 1 | Main access is 16-bit |
| m_addr | input | AW | Main byte offset |
| m_wdata | input | 16 | Main write data |
| m_rdata | output | 16 | Main read data for word at m_addr |
| s_wr | input | 1 | Sub write strobe |
| s_word | input | 1 | Sub access is 16-bit |
| s_addr | input | AW | Sub byte offset |
| s_wdata | input | 16 | Sub write data |
| s_rdata | output | 16 | Sub read data for word at s_addr |
| sub_run | output | 1 | Sub processor run level (0 = held in reset) |
| sub_busreq | output | 1 | Sub bus request level |
| sub_reset_pulse | output | 1 | One-cycle sub reset pulse |
| sub_irq2 | output | 1 | One-cycle level-2 interrupt request |
| prg_bank | output | 2 | Exported bank field |

## Verification
The hardest state to reach is the reset-pending flag when the control bits already look like a release target. The bench gets there by first releasing with 01, then writing 00 and 11. The 11 write must leave pending set without a pulse, and a later 01 must still pulse. The doorbell is rung once with the mask clear and once with it set. This shows that the sub side alone gates a main-side action.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    // Per-access byte lane decode shared by both ports.
    typedef struct packed {
        logic       hi_en;
        logic       lo_en;
        logic [7:0] hi;
        logic [7:0] lo;
    } lane_t;

    localparam logic [7:0] MASK_KEEP   = 8'h7E;
    localparam logic [7:0] BANK2_RMASK = 8'hC7;
    localparam int         IEN2_BIT    = 2;

    // Byte access: data in wdata[7:0], lane picked by addr bit 0.
    // Word access: both lanes, big-endian order.
    function automatic lane_t lane_decode(input logic word, input logic a0,
                                          input logic [15:0] wdata);
        lane_t l;
        if (word) begin
            l.hi_en = 1'b1;
            l.lo_en = 1'b1;
            l.hi    = wdata[15:8];
            l.lo    = wdata[7:0];
        end else begin
            l.hi_en = ~a0;
            l.lo_en = a0;
            l.hi    = wdata[7:0];
            l.lo    = wdata[7:0];
        end
        return l;
    endfunction

endpackage

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
    import dcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       w0_i,
    input  logic       w2_i,
    input  logic       mask_i,
    input  lane_t      m_lane_i,
    input  lane_t      s_lane_i,
    output logic       run_o,
    output logic       busreq_o,
    output logic       rst_pulse_o,
    output logic       irq2_o,
    output logic [7:0] b2_o,
    output logic [7:0] b3_o,
    output logic [7:0] mask_o
);

    typedef struct packed {
        logic       run;
        logic       busreq;
        logic       pending;
        logic       rst_pulse;
        logic       irq2;
        logic [7:0] b2;
        logic [7:0] b3;
        logic [7:0] mask;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [1:0] ctl_new;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        st_d.irq2      = 1'b0;
        ctl_new        = m_lane_i.lo[1:0];
        if (!ctl_new[0]) begin
            ctl_new[1] = 1'b1;
        end

        if (w0_i && m_lane_i.hi_en && m_lane_i.hi[0] && st_q.mask[IEN2_BIT]) begin
            st_d.irq2 = 1'b1;
        end

        if (w0_i && m_lane_i.lo_en) begin
            st_d.run    = ctl_new[0];
            st_d.busreq = ctl_new[1];
            if (!ctl_new[0]) begin
                st_d.pending = 1'b1;
            end else if (ctl_new == 2'b01 && st_q.pending) begin
                st_d.pending   = 1'b0;
                st_d.rst_pulse = 1'b1;
            end
        end

        if (w2_i) begin
            if (m_lane_i.hi_en) st_d.b2 = m_lane_i.hi;
            if (m_lane_i.lo_en) st_d.b3 = m_lane_i.lo;
        end

        if (mask_i) begin
            st_d.mask = s_lane_i.lo & MASK_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.busreq  <= 1'b1;
            st_q.pending <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o       = st_q.run;
    assign busreq_o    = st_q.busreq;
    assign rst_pulse_o = st_q.rst_pulse;
    assign irq2_o      = st_q.irq2;
    assign b2_o        = st_q.b2;
    assign b3_o        = st_q.b3;
    assign mask_o      = st_q.mask;

    assert_bus_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> st_q.busreq);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |=> !st_q.rst_pulse);

    assert_pulse_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |-> (st_q.run && !st_q.busreq));

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq2 |-> $past(st_q.mask[IEN2_BIT]));

endmodule

// File: rtl/dcm_flags.sv
module dcm_flags
    import dcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m_wr_i,
    input  lane_t      m_lane_i,
    input  logic       s_wr_i,
    input  lane_t      s_lane_i,
    output logic [7:0] fm_o,
    output logic [7:0] fs_o
);

    typedef struct packed {
        logic [7:0] fm;
        logic [7:0] fs;
    } flags_t;

    flags_t st_d, st_q;

    // Each side only ever reaches its own byte: main takes the high-lane
    // value (word bits 15:8 or byte data), sub takes the low-lane value.
    always_comb begin
        st_d = st_q;
        if (m_wr_i) st_d.fm = m_lane_i.hi;
        if (s_wr_i) st_d.fs = s_lane_i.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fm_o = st_q.fm;
    assign fs_o = st_q.fs;

    assert_main_flag_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !m_wr_i |=> $stable(st_q.fm));

    assert_sub_flag_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_wr_i |=> $stable(st_q.fs));

endmodule

// File: rtl/dcm_mbox.sv
module dcm_mbox
    import dcm_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [IW-1:0]          idx_i,
    input  lane_t                  lane_i,
    output logic [WORDS-1:0][15:0] words_o
);

    typedef struct packed {
        logic [WORDS-1:0][15:0] w;
    } mbox_t;

    mbox_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WORDS; i++) begin
            if (wr_i && idx_i == IW'(i)) begin
                if (lane_i.hi_en) st_d.w[i][15:8] = lane_i.hi;
                if (lane_i.lo_en) st_d.w[i][7:0]  = lane_i.lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words_o = st_q.w;

    assert_bank_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.w));

endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox
    import dcm_pkg::*;
#(
    parameter int AW          = 6,
    parameter int MBOX_WORDS  = 8,
    parameter int M2S_BASE    = 'h10,
    parameter int S2M_BASE    = 'h20,
    parameter int FLAG_OFF    = 'h0E,
    parameter int MASK_OFF    = 'h32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_wr,
    input  logic          m_word,
    input  logic [AW-1:0] m_addr,
    input  logic [15:0]   m_wdata,
    output logic [15:0]   m_rdata,
    input  logic          s_wr,
    input  logic          s_word,
    input  logic [AW-1:0] s_addr,
    input  logic [15:0]   s_wdata,
    output logic [15:0]   s_rdata,
    output logic          sub_run,
    output logic          sub_busreq,
    output logic          sub_reset_pulse,
    output logic          sub_irq2,
    output logic [1:0]    prg_bank
);

    localparam int IW = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
    localparam int SPAN = 2 * MBOX_WORDS;
    localparam logic [AW-1:0] M2S_LO = AW'(M2S_BASE);
    localparam logic [AW-1:0] M2S_HI = AW'(M2S_BASE + SPAN);
    localparam logic [AW-1:0] S2M_LO = AW'(S2M_BASE);
    localparam logic [AW-1:0] S2M_HI = AW'(S2M_BASE + SPAN);
    localparam logic [AW-2:0] W_CTRL = '0;
    localparam logic [AW-2:0] W_BANK = (AW-1)'(1);
    localparam logic [AW-2:0] W_FLAG = (AW-1)'(FLAG_OFF / 2);
    localparam logic [AW-2:0] W_MASK = (AW-1)'(MASK_OFF / 2);

    lane_t m_lane, s_lane;
    logic m_is_ctrl, m_is_bank, m_is_flag, m_in_m2s, m_in_s2m;
    logic s_is_flag, s_is_mask, s_in_m2s, s_in_s2m;
    logic [AW-1:0] m_off_m2s, m_off_s2m, s_off_m2s, s_off_s2m;
    logic run_w, busreq_w, pulse_w, irq_w;
    logic [7:0] b2_w, b3_w, mask_w, fm_w, fs_w;
    logic [MBOX_WORDS-1:0][15:0] m2s_w, s2m_w;

    always_comb begin
        m_lane    = lane_decode(m_word, m_addr[0], m_wdata);
        s_lane    = lane_decode(s_word, s_addr[0], s_wdata);
        m_is_ctrl = m_addr[AW-1:1] == W_CTRL;
        m_is_bank = m_addr[AW-1:1] == W_BANK;
        m_is_flag = m_addr[AW-1:1] == W_FLAG;
        s_is_flag = s_addr[AW-1:1] == W_FLAG;
        s_is_mask = s_addr[AW-1:1] == W_MASK;
        m_in_m2s  = (m_addr >= M2S_LO) && (m_addr < M2S_HI);
        m_in_s2m  = (m_addr >= S2M_LO) && (m_addr < S2M_HI);
        s_in_m2s  = (s_addr >= M2S_LO) && (s_addr < M2S_HI);
        s_in_s2m  = (s_addr >= S2M_LO) && (s_addr < S2M_HI);
        m_off_m2s = m_addr - M2S_LO;
        m_off_s2m = m_addr - S2M_LO;
        s_off_m2s = s_addr - M2S_LO;
        s_off_s2m = s_addr - S2M_LO;
    end

    dcm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .w0_i        (m_wr && m_is_ctrl),
        .w2_i        (m_wr && m_is_bank),
        .mask_i      (s_wr && s_is_mask && s_lane.lo_en),
        .m_lane_i    (m_lane),
        .s_lane_i    (s_lane),
        .run_o       (run_w),
        .busreq_o    (busreq_w),
        .rst_pulse_o (pulse_w),
        .irq2_o      (irq_w),
        .b2_o        (b2_w),
        .b3_o        (b3_w),
        .mask_o      (mask_w)
    );

    dcm_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_wr_i   (m_wr && m_is_flag),
        .m_lane_i (m_lane),
        .s_wr_i   (s_wr && s_is_flag),
        .s_lane_i (s_lane),
        .fm_o     (fm_w),
        .fs_o     (fs_w)
    );

    dcm_mbox #(.WORDS(MBOX_WORDS)) u_m2s (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (m_wr && m_in_m2s),
        .idx_i   (m_off_m2s[IW:1]),
        .lane_i  (m_lane),
        .words_o (m2s_w)
    );

    dcm_mbox #(.WORDS(MBOX_WORDS)) u_s2m (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (s_wr && s_in_s2m),
        .idx_i   (s_off_s2m[IW:1]),
        .lane_i  (s_lane),
        .words_o (s2m_w)
    );

    always_comb begin
        m_rdata = '0;
        if (m_is_ctrl)      m_rdata = {mask_w[IEN2_BIT], 13'b0, busreq_w, run_w};
        else if (m_is_bank) m_rdata = {b2_w, b3_w & BANK2_RMASK};
        else if (m_is_flag) m_rdata = {fm_w, fs_w};
        else if (m_in_m2s)  m_rdata = m2s_w[m_off_m2s[IW:1]];
        else if (m_in_s2m)  m_rdata = s2m_w[m_off_s2m[IW:1]];
    end

    always_comb begin
        s_rdata = '0;
        if (s_is_flag)      s_rdata = {fm_w, fs_w};
        else if (s_is_mask) s_rdata = {8'h00, mask_w};
        else if (s_in_m2s)  s_rdata = m2s_w[s_off_m2s[IW:1]];
        else if (s_in_s2m)  s_rdata = s2m_w[s_off_s2m[IW:1]];
    end

    assign sub_run         = run_w;
    assign sub_busreq      = busreq_w;
    assign sub_reset_pulse = pulse_w;
    assign sub_irq2        = irq_w;
    assign prg_bank        = b3_w[7:6];

    assert_irq_from_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sub_irq2 |-> $past(m_wr));

    assert_pulse_from_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sub_reset_pulse |-> $past(m_wr));

    assert_mask_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w & ~MASK_KEEP) == 8'h00);

endmodule

// File: tb/dual_cpu_mailbox_tb_top.sv
module dual_cpu_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_wr = 1'b0, m_word = 1'b0, s_wr = 1'b0, s_word = 1'b0;
    logic [5:0]  m_addr = '0, s_addr = '0;
    logic [15:0] m_wdata = '0, s_wdata = '0;
    logic [15:0] m_rdata, s_rdata;
    logic        sub_run, sub_busreq, sub_reset_pulse, sub_irq2;
    logic [1:0]  prg_bank;
    int          total = 0, fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_cpu_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_wr(m_wr), .m_word(m_word), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_wr(s_wr), .s_word(s_word), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .sub_run(sub_run), .sub_busreq(sub_busreq), .sub_reset_pulse(sub_reset_pulse),
        .sub_irq2(sub_irq2), .prg_bank(prg_bank)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write completes at the posedge; returns at the next negedge.
    task automatic m_write(input bit word, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        m_wr = 1'b1; m_word = word; m_addr = a; m_wdata = d;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    task automatic s_write(input bit word, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        s_wr = 1'b1; s_word = word; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic m_read(input logic [5:0] a, output logic [15:0] d);
        m_addr = a; #1; d = m_rdata;
    endtask

    task automatic s_read(input logic [5:0] a, output logic [15:0] d);
        s_addr = a; #1; s_rdata_cap(d);
    endtask

    task automatic s_rdata_cap(output logic [15:0] d);
        d = s_rdata;
    endtask

    task automatic t_reset_state;
        logic [15:0] v;
        m_read(6'h00, v); chk("R1 main word0 after reset", v, 16'h0002);
        m_read(6'h02, v); chk("R1 bank word after reset", v, 16'h0000);
        m_read(6'h0E, v); chk("R1 flags after reset", v, 16'h0000);
        s_read(6'h10, v); chk("R1 mailbox after reset", v, 16'h0000);
        chk("R1 pulses low", {14'b0, sub_reset_pulse, sub_irq2}, 16'h0000);
    endtask

    task automatic t_release;
        m_write(1'b0, 6'h01, 16'h0001);
        chk("R3 reset pulse high", {15'b0, sub_reset_pulse}, 16'h0001);
        chk("R3 run and bus after release", {14'b0, sub_busreq, sub_run}, 16'h0001);
        @(negedge clk);
        chk("R3 reset pulse one cycle", {15'b0, sub_reset_pulse}, 16'h0000);
    endtask

    task automatic t_pending_cases;
        logic [15:0] v;
        m_write(1'b0, 6'h01, 16'h0001);
        chk("R4 no pulse without pending", {15'b0, sub_reset_pulse}, 16'h0000);
        m_write(1'b0, 6'h01, 16'h0000);
        m_read(6'h00, v); chk("R2 reset forces bus request", v, 16'h0002);
        m_write(1'b0, 6'h01, 16'h0003);
        chk("R4 no pulse on 11", {15'b0, sub_reset_pulse}, 16'h0000);
        chk("R4 run with bus held", {14'b0, sub_busreq, sub_run}, 16'h0003);
        m_write(1'b0, 6'h01, 16'h0001);
        chk("R4 pending kept through 11", {15'b0, sub_reset_pulse}, 16'h0001);
    endtask

    task automatic t_doorbell;
        logic [15:0] v;
        m_write(1'b0, 6'h00, 16'h0001);
        chk("R6 doorbell masked", {15'b0, sub_irq2}, 16'h0000);
        @(negedge clk);
        chk("R6 doorbell masked later", {15'b0, sub_irq2}, 16'h0000);
        s_write(1'b0, 6'h33, 16'h00FF);
        s_read(6'h32, v); chk("R13 mask keeps 7E", v, 16'h007E);
        m_read(6'h00, v); chk("R7 word0 shows enable", v, 16'h8001);
        m_write(1'b0, 6'h00, 16'h0001);
        chk("R5 irq pulse", {15'b0, sub_irq2}, 16'h0001);
        @(negedge clk);
        chk("R5 irq one cycle", {15'b0, sub_irq2}, 16'h0000);
        m_write(1'b1, 6'h00, 16'h0101);
        chk("R5 irq from word write", {14'b0, sub_irq2, sub_reset_pulse}, 16'h0002);
    endtask

    task automatic t_bank;
        logic [15:0] v;
        m_write(1'b1, 6'h02, 16'hABFF);
        m_read(6'h02, v); chk("R8 word2 read mask", v, 16'hABC7);
        chk("R8 bank field", {14'b0, prg_bank}, 16'h0003);
        m_write(1'b0, 6'h03, 16'h0040);
        m_read(6'h02, v); chk("R8 byte write bank", v, 16'hAB40);
        chk("R8 bank field after byte", {14'b0, prg_bank}, 16'h0001);
    endtask

    task automatic t_flags;
        logic [15:0] v;
        m_write(1'b0, 6'h0F, 16'h005A);
        m_read(6'h0E, v); chk("R9 main byte to odd addr", v, 16'h5A00);
        s_write(1'b0, 6'h0E, 16'h0033);
        s_read(6'h0E, v); chk("R9 sub byte to even addr", v, 16'h5A33);
        m_write(1'b1, 6'h0E, 16'h1234);
        m_read(6'h0E, v); chk("R10 main word high only", v, 16'h1233);
        s_write(1'b1, 6'h0E, 16'h7788);
        s_read(6'h0E, v); chk("R10 sub word low only", v, 16'h1288);
    endtask

    task automatic t_mailbox;
        logic [15:0] v;
        m_write(1'b1, 6'h10, 16'hBEEF);
        s_read(6'h10, v); chk("R11 sub reads main bank", v, 16'hBEEF);
        s_write(1'b1, 6'h12, 16'h1111);
        m_read(6'h12, v); chk("R11 sub write to main bank ignored", v, 16'h0000);
        s_write(1'b1, 6'h2E, 16'hCAFE);
        m_read(6'h2E, v); chk("R11 main reads sub bank", v, 16'hCAFE);
        m_write(1'b1, 6'h2E, 16'h0000);
        s_read(6'h2E, v); chk("R11 main write to sub bank ignored", v, 16'hCAFE);
        m_write(1'b0, 6'h11, 16'h0055);
        m_read(6'h10, v); chk("R12 odd byte lane", v, 16'hBE55);
        m_write(1'b0, 6'h10, 16'h0066);
        s_read(6'h10, v); chk("R12 even byte lane", v, 16'h6655);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_release();
        t_pending_cases();
        t_doorbell();
        t_bank();
        t_flags();
        t_mailbox();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule